// File: doc/BRIEF.md
# Addressed Serial and Parallel State Loader

This block is the digital control front end for a 9-bit state register, such as the one that sets the step of a phase shifter. A mode input picks how the register is loaded.

In parallel mode, nine input lines supply the value. A load-enable input either latches that value on a high-then-low pulse or, when held high, lets the lines pass straight through to the state output.

In serial mode, a frame is shifted in on a clock. The frame is a 9-bit data word followed by a 4-bit address. When load-enable goes high, the received address is compared with four strap inputs. The state register takes the data word only on a match. Because of this address check, several of these blocks can share one serial bus, each with its own strap value.

Two serial outputs are provided. One is a combinational copy of the serial input, used for fanning the bus out to neighbours. The other is the oldest stage of the shift register.

Top module: `phase_ctl_frontend`

## Requirements
- R1: While `rstN` is low, `stateOut` is all zeros and `serTail` is 0, independent of any clock.
- R2: With `modeSerial` = 0 and `loadEn` low, changes on `parBits` leave `stateOut` unchanged.
- R3: With `modeSerial` = 0, raising and then lowering `loadEn` loads the `parBits` value present while `loadEn` was high into `stateOut`. That value is kept after `loadEn` falls, even if `parBits` later changes.
- R4: With `modeSerial` = 0 and `loadEn` held high, `stateOut` equals `parBits` and follows changes without any `clk` edge.
- R5: With `modeSerial` = 1 and `loadEn` low, each rising `clk` edge shifts `serIn` into the 13-stage register. The first bit sent lands in frame position 0. Positions 0 to 8 form the data word, least significant bit first. Positions 9 to 12 form the address, with address bit 0 at position 9.
- R6: In serial mode, raising `loadEn` when the received address equals `strap` loads the data word into `stateOut`. The value is held after `loadEn` falls.
- R7: In serial mode, raising `loadEn` when the received address differs from `strap` in any bit leaves `stateOut` unchanged.
- R8: In serial mode with `loadEn` low, shifting and activity on `parBits` never change `stateOut`.
- R9: `serEcho` equals `serIn` at all times, with no dependence on `clk`.
- R10: `serTail` is the oldest stage of the shift register and changes only on a rising `clk` edge. Right after a full 13-bit frame, it equals data bit 0 of that frame.
- R11: The shift register holds while `modeSerial` = 0, so `serTail` is stable through parallel-mode activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial shift clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSerial | input | 1 | 0 selects the parallel lines, 1 selects the addressed serial frame |
| loadEn | input | 1 | Load enable: parallel latch or pass-through, serial frame commit |
| parBits | input | 9 | Parallel state value |
| serIn | input | 1 | Serial data input |
| strap | input | 4 | Static address this block answers to |
| stateOut | output | 9 | Current state value |
| serEcho | output | 1 | Combinational copy of serIn |
| serTail | output | 1 | Oldest shift register stage |

## Verification
The bench builds the block with its default widths: a 9-bit data word and a 4-bit address, for a 13-bit frame. A 4-bit address keeps all sixteen strap values within reach of random draws. It also makes it practical to send frames whose address differs from the strap by a single bit next to frames that match exactly.

A 9-bit data word lets directed all-ones and alternating patterns sit alongside random values. Those patterns expose any swap or offset between the data and address fields.

// File: rtl/phase_ctl_pkg.sv
package phase_ctl_pkg;

  // Strobes handed from the control decode to the datapath
  typedef struct packed {
    logic shift;       // advance the serial shift register on clk
    logic capture;     // open the holding latch
    logic pickSerial;  // latch source: 1 = received data word, 0 = parallel lines
  } ctlStrobe_t;

endpackage

// File: rtl/phase_ctl_control.sv
module phase_ctl_control
  import phase_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              modeSerial,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic [ADDR_W-1:0] strap,
  output ctlStrobe_t        strobe
);

  logic addrHit;

  always_comb begin
    addrHit           = (rxAddr == strap);
    strobe.pickSerial = modeSerial;
    // the frame only moves while the holding latch is closed
    strobe.shift      = modeSerial & ~loadEn;
    // parallel mode opens on loadEn alone; serial mode also needs an address hit
    strobe.capture    = loadEn & (~modeSerial | addrHit);
  end

endmodule

// File: rtl/phase_ctl_datapath.sv
module phase_ctl_datapath
  import phase_ctl_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic [DATA_W-1:0] parBits,
  input  ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] rxAddr,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] stateOut,
  output logic              serTail
);

  localparam int FRAME_W = DATA_W + ADDR_W;

  logic [FRAME_W-1:0] shiftQ;
  logic [DATA_W-1:0]  nextState;
  logic [DATA_W-1:0]  holdQ;

  // new bits enter at the top and move toward index 0,
  // so the first bit of a frame ends up in position 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strobe.shift) begin
      shiftQ <= {serIn, shiftQ[FRAME_W-1:1]};
    end
  end

  assign rxData  = shiftQ[DATA_W-1:0];
  assign rxAddr  = shiftQ[FRAME_W-1:DATA_W];
  assign serTail = shiftQ[0];

  assign nextState = strobe.pickSerial ? rxData : parBits;

  // transparent holding latch with asynchronous clear
  always_latch begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (strobe.capture) begin
      holdQ <= nextState;
    end
  end

  assign stateOut = holdQ;

endmodule

// File: rtl/phase_ctl_frontend.sv
module phase_ctl_frontend
  import phase_ctl_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSerial,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] parBits,
  input  logic              serIn,
  input  logic [ADDR_W-1:0] strap,
  output logic [DATA_W-1:0] stateOut,
  output logic              serEcho,
  output logic              serTail
);

  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] rxAddr;
  logic [DATA_W-1:0] rxData;

  phase_ctl_control #(
    .ADDR_W(ADDR_W)
  ) ctl (
    .modeSerial(modeSerial),
    .loadEn    (loadEn),
    .rxAddr    (rxAddr),
    .strap     (strap),
    .strobe    (strobe)
  );

  phase_ctl_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) dp (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .parBits (parBits),
    .strobe  (strobe),
    .rxAddr  (rxAddr),
    .rxData  (rxData),
    .stateOut(stateOut),
    .serTail (serTail)
  );

  // buffered pass-through for daisy fan-out of the serial bus
  assign serEcho = serIn;

endmodule

// File: rtl/phase_ctl_checker.sv
module phase_ctl_checker #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeSerial,
  input logic              loadEn,
  input logic [DATA_W-1:0] parBits,
  input logic              serIn,
  input logic [ADDR_W-1:0] strap,
  input logic [ADDR_W-1:0] rxAddr,
  input logic [DATA_W-1:0] rxData,
  input logic [DATA_W-1:0] stateOut,
  input logic              serTail
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (stateOut == '0) && (serTail == 1'b0));

  // R4
  direct_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSerial && loadEn) |-> (stateOut == parBits));

  // R5
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSerial && !loadEn) |=> (rxAddr[ADDR_W-1] == $past(serIn)));

  // R6
  match_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSerial && loadEn && (rxAddr == strap)) |-> (stateOut == rxData));

  // R7
  mismatch_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSerial && loadEn && $past(modeSerial && loadEn) && (rxAddr != strap))
      |-> $stable(stateOut));

  // R8
  serial_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSerial && !loadEn && $past(modeSerial && !loadEn)) |-> $stable(stateOut));

endmodule

bind phase_ctl_frontend phase_ctl_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeSerial(modeSerial),
  .loadEn    (loadEn),
  .parBits   (parBits),
  .serIn     (serIn),
  .strap     (strap),
  .rxAddr    (rxAddr),
  .rxData    (rxData),
  .stateOut  (stateOut),
  .serTail   (serTail)
);

// File: tb/phase_ctl_frontend_test.sv
module phase_ctl_frontend_test;

  localparam int DW = 9;
  localparam int AW = 4;
  localparam int FW = DW + AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeSerial = 1'b0;
  logic          loadEn = 1'b0;
  logic          serIn = 1'b0;
  logic [DW-1:0] parBits = '0;
  logic [AW-1:0] strap = '0;
  wire  [DW-1:0] stateOut;
  wire           serEcho;
  wire           serTail;

  int            nCmp = 0;
  int            nBad = 0;
  logic [DW-1:0] expState = '0;
  bit            finished = 0;

  always #2 clk = ~clk;

  phase_ctl_frontend #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .modeSerial(modeSerial), .loadEn(loadEn),
    .parBits(parBits), .serIn(serIn), .strap(strap),
    .stateOut(stateOut), .serEcho(serEcho), .serTail(serTail)
  );

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [FW-1:0] mkFrame(logic [DW-1:0] d, logic [AW-1:0] a);
    return {a, d};
  endfunction

  function automatic logic [DW-1:0] serialNext(logic [DW-1:0] cur, logic [DW-1:0] d,
                                               logic [AW-1:0] a, logic [AW-1:0] s);
    return (a == s) ? d : cur;
  endfunction

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  task automatic sendFrame(logic [DW-1:0] d, logic [AW-1:0] a);
    logic [FW-1:0] f;
    f = mkFrame(d, a);
    for (int i = 0; i < FW; i++) begin
      @(negedge clk);
      serIn   = f[i];
      parBits = DW'($urandom);
      #1;
      chk("R9 echo", {15'd0, serEcho}, {15'd0, serIn});
      chk("R8 state held while shifting", {7'd0, stateOut}, {7'd0, expState});
    end
  endtask

  task automatic serialOp(logic [DW-1:0] d, logic [AW-1:0] a, logic [AW-1:0] s);
    @(negedge clk);
    modeSerial = 1'b1;
    loadEn     = 1'b0;
    strap      = s;
    sendFrame(d, a);
    @(negedge clk);
    loadEn = 1'b1;
    #1;
    chk("R10 tail after frame", {15'd0, serTail}, {15'd0, d[0]});
    expState = serialNext(expState, d, a, s);
    if (a == s) chk("R6 match load", {7'd0, stateOut}, {7'd0, expState});
    else        chk("R7 mismatch keep", {7'd0, stateOut}, {7'd0, expState});
    @(negedge clk);
    loadEn = 1'b0;
    #1;
    chk("R6 held after commit", {7'd0, stateOut}, {7'd0, expState});
  endtask

  task automatic latchedOp(logic [DW-1:0] v);
    logic tailBefore;
    @(negedge clk);
    modeSerial = 1'b0;
    loadEn     = 1'b0;
    #1;
    tailBefore = serTail;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      parBits = DW'($urandom);
      serIn   = 1'($urandom);
      #1;
      chk("R2 lines ignored with LE low", {7'd0, stateOut}, {7'd0, expState});
      chk("R11 tail stable in parallel mode", {15'd0, serTail}, {15'd0, tailBefore});
    end
    @(negedge clk);
    parBits = v;
    @(negedge clk);
    loadEn   = 1'b1;
    expState = v;
    @(negedge clk);
    loadEn = 1'b0;
    #1;
    chk("R3 pulse loads value", {7'd0, stateOut}, {7'd0, expState});
    @(negedge clk);
    parBits = ~v;
    #1;
    chk("R3 value kept after LE low", {7'd0, stateOut}, {7'd0, expState});
  endtask

  task automatic directOp();
    @(negedge clk);
    modeSerial = 1'b0;
    loadEn     = 1'b1;
    #1;
    chk("R4 direct follows", {7'd0, stateOut}, {7'd0, parBits});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      parBits = DW'($urandom);
      #0;
      #1;
      chk("R4 direct follows without clock", {7'd0, stateOut}, {7'd0, parBits});
    end
    @(negedge clk);
    loadEn   = 1'b0;
    expState = parBits;
    #1;
    chk("R3 direct exit keeps value", {7'd0, stateOut}, {7'd0, expState});
  endtask

  task automatic resetOp();
    @(negedge clk);
    loadEn = 1'b0;
    rstN   = 1'b0;
    #1;
    expState = '0;
    chk("R1 state cleared", {7'd0, stateOut}, 16'd0);
    chk("R1 tail cleared", {15'd0, serTail}, 16'd0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      printSummary();
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] s;
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    #1;
    chk("R1 state at reset", {7'd0, stateOut}, 16'd0);
    chk("R1 tail at reset", {15'd0, serTail}, 16'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // directed corners
    serialOp(9'h1FF, 4'hA, 4'hA);
    serialOp(9'h155, 4'hB, 4'hA);   // single address bit differs
    serialOp(9'h0AA, 4'h3, 4'h3);
    serialOp(9'h000, 4'h0, 4'h0);
    latchedOp(9'h123);
    directOp();
    serialOp(9'h101, 4'hF, 4'hF);
    resetOp();
    serialOp(9'h1F0, 4'h7, 4'h8);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      case ($urandom % 5)
        0, 1: begin
          s = AW'($urandom);
          a = ($urandom % 2 == 0) ? s : AW'($urandom);
          serialOp(DW'($urandom), a, s);
        end
        2: latchedOp(DW'($urandom));
        3: directOp();
        default: begin
          s = AW'($urandom);
          serialOp(DW'($urandom), s ^ (AW'(1) << ($urandom % AW)), s);
        end
      endcase
    end

    finished = 1;
    printSummary();
    $finish;
  end

endmodule